// File: doc/BRIEF.md
# Debug Test Access Port with Emulation Registers

This block is a soft test access port that an external debugger drives through a four-wire serial scan interface. A sixteen-state controller, stepped by the scan clock and steered by the mode-select pin, moves between resetting the port, loading an instruction, moving data through a selected register, and idling. The loaded instruction acts as an address. It chooses one of several data registers of different lengths that face a processor core or a simple state machine: a control word with the halt request, an 8-bit injected instruction, a read-only status pair, a 32-bit data mailbox and a live program counter. An unknown instruction selects a 1-bit bypass stage, so the port can sit in a chain of devices wired output to input.

All scan-side registers live in the scan clock domain. A new value reaches the core side only through Update-DR. The new value is announced by a toggle that passes through a synchronizer into the core clock. The whole bundle of core-side outputs is then registered at one edge. Each update of the instruction register also makes exactly one core-clock pulse on the execute line.

Top module: `dbg_tap`

## Requirements
- R1: Reset (rst_n low) puts the controller in Test-Logic-Reset, selects the bypass instruction and clears every core-side output. Five scan-clock rising edges with the mode pin high also reach Test-Logic-Reset and select bypass, but they leave the core-side outputs unchanged.
- R2: The instruction register is 4 bits wide and is shifted least significant bit first. Capture-IR loads 4'b0001, and that value leaves on the serial output during the first four shift cycles.
- R3: Instruction codes: 1 selects control (5 bits), 2 selects the injected instruction (8 bits), 3 selects status (2 bits), 4 selects data (32 bits) and 5 selects the program counter (32 bits). Every other code selects a 1-bit bypass stage that captures 0.
- R4: Data shifts least significant bit first. The serial input enters at the top bit of the selected length, so an input bit comes out again after exactly that many shift cycles. Through bypass the delay is one cycle.
- R5: The serial output changes on the falling scan-clock edge. The output-enable is high only while the controller is in Shift-IR or Shift-DR.
- R6: An update of the control register sets emu_req from bit 0 and emu_ctl from bits 4:1. emu_req is a level and holds until the next control update. Capture reads both back in the same positions.
- R7: An update of the injected-instruction register loads emu_ir and makes exactly one clk-wide pulse on emu_exec, one pulse per update.
- R8: Capture of the status register returns emu_ack in bit 0 and emu_rdy in bit 1. An update of the status register changes no core-side output.
- R9: Capture of the data register loads data_from_core. An update of the data register drives data_to_core.
- R10: Capture of the program-counter register loads dbg_pc while the core keeps running. emu_req is not affected.
- R11: Core-side outputs change together on the third clk rising edge after the scan-clock rising edge that leaves Update-DR, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| tck | input | 1 | Scan clock |
| tms | input | 1 | Scan mode select, sampled on the rising scan-clock edge |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, changes on the falling scan-clock edge |
| tdo_oe | output | 1 | High while shifting, output enable for tdo |
| emu_req | output | 1 | Level request for the core to enter emulation |
| emu_ctl | output | CTL_W | Emulation control bits |
| emu_ir | output | EIR_W | Instruction to be executed by the core |
| emu_exec | output | 1 | One clk-wide execute pulse |
| emu_ack | input | 1 | Core has entered emulation |
| emu_rdy | input | 1 | Core can accept another instruction |
| data_to_core | output | DATA_W | Mailbox value written by the debugger |
| data_from_core | input | DATA_W | Mailbox value offered by the core |
| dbg_pc | input | PC_W | Live program counter of the core |

## Verification
If the controller state is wrong, the serial output shows it at once. The capture pattern, bypass delay or read-back value is off within the same scan, and the output-enable comes up at the wrong time. A wrong selected length shows up as a shifted read-back in the next scan. A fault in the clock crossing shows on the core side on the exact clk edge. Outputs then move early, late, or without an update, or the execute line stays high for more than one cycle. The bench holds an expected image of every core-side output and compares it on each clk, so such a fault is caught within one core cycle.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        TLR    = 4'd0,
        RTI    = 4'd1,
        SEL_DR = 4'd2,
        CAP_DR = 4'd3,
        SH_DR  = 4'd4,
        EX1_DR = 4'd5,
        PA_DR  = 4'd6,
        EX2_DR = 4'd7,
        UPD_DR = 4'd8,
        SEL_IR = 4'd9,
        CAP_IR = 4'd10,
        SH_IR  = 4'd11,
        EX1_IR = 4'd12,
        PA_IR  = 4'd13,
        EX2_IR = 4'd14,
        UPD_IR = 4'd15
    } tap_state_e;

    localparam logic [IR_W-1:0] INS_CTRL   = 4'h1;
    localparam logic [IR_W-1:0] INS_EIR    = 4'h2;
    localparam logic [IR_W-1:0] INS_STAT   = 4'h3;
    localparam logic [IR_W-1:0] INS_DATA   = 4'h4;
    localparam logic [IR_W-1:0] INS_PC     = 4'h5;
    localparam logic [IR_W-1:0] INS_BYPASS = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms_i,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            TLR:    fsm_d.st = tms_i ? TLR    : RTI;
            RTI:    fsm_d.st = tms_i ? SEL_DR : RTI;
            SEL_DR: fsm_d.st = tms_i ? SEL_IR : CAP_DR;
            CAP_DR: fsm_d.st = tms_i ? EX1_DR : SH_DR;
            SH_DR:  fsm_d.st = tms_i ? EX1_DR : SH_DR;
            EX1_DR: fsm_d.st = tms_i ? UPD_DR : PA_DR;
            PA_DR:  fsm_d.st = tms_i ? EX2_DR : PA_DR;
            EX2_DR: fsm_d.st = tms_i ? UPD_DR : SH_DR;
            UPD_DR: fsm_d.st = tms_i ? SEL_DR : RTI;
            SEL_IR: fsm_d.st = tms_i ? TLR    : CAP_IR;
            CAP_IR: fsm_d.st = tms_i ? EX1_IR : SH_IR;
            SH_IR:  fsm_d.st = tms_i ? EX1_IR : SH_IR;
            EX1_IR: fsm_d.st = tms_i ? UPD_IR : PA_IR;
            PA_IR:  fsm_d.st = tms_i ? EX2_IR : PA_IR;
            EX2_IR: fsm_d.st = tms_i ? UPD_IR : SH_IR;
            UPD_IR: fsm_d.st = tms_i ? SEL_DR : RTI;
            default: fsm_d.st = TLR;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: TLR};
        else        fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.st;

    // R1: five consecutive high mode samples always land in Test-Logic-Reset
    assert_tlr_five_ones_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (tms_i && $past(tms_i, 1) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
        |=> (fsm_q.st == TLR));

endmodule

// File: rtl/dbg_tap_regs.sv
module dbg_tap_regs
    import dbg_tap_pkg::*;
#(
    parameter int CTL_W  = 4,
    parameter int EIR_W  = 8,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi_i,
    input  tap_state_e        state_i,
    input  logic              emu_ack_i,
    input  logic              emu_rdy_i,
    input  logic [DATA_W-1:0] data_from_core_i,
    input  logic [PC_W-1:0]   dbg_pc_i,
    output logic              tdo_o,
    output logic              tdo_en_o,
    output logic              req_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [EIR_W-1:0]  eir_o,
    output logic [DATA_W-1:0] data_o,
    output logic              upd_tog_o,
    output logic              exec_tog_o
);

    localparam int CTL_LEN = CTL_W + 1;
    localparam int STAT_W  = 2;
    localparam int MAX_A   = (CTL_LEN > EIR_W) ? CTL_LEN : EIR_W;
    localparam int MAX_B   = (DATA_W > PC_W) ? DATA_W : PC_W;
    localparam int SR_W    = (MAX_A > MAX_B) ? MAX_A : MAX_B;

    typedef struct packed {
        logic [IR_W-1:0]   ir;
        logic [IR_W-1:0]   ir_sr;
        logic [SR_W-1:0]   dr_sr;
        logic              req;
        logic [CTL_W-1:0]  ctl;
        logic [EIR_W-1:0]  eir;
        logic [DATA_W-1:0] data;
        logic              upd_tog;
        logic              exec_tog;
    } regs_t;

    regs_t r_d, r_q;
    logic  tdo_q, tdo_en_q;

    function automatic int sel_len(input logic [IR_W-1:0] code);
        case (code)
            INS_CTRL: return CTL_LEN;
            INS_EIR:  return EIR_W;
            INS_STAT: return STAT_W;
            INS_DATA: return DATA_W;
            INS_PC:   return PC_W;
            default:  return 1;
        endcase
    endfunction

    int              len;
    logic [SR_W-1:0] shifted;

    always_comb begin
        r_d     = r_q;
        len     = sel_len(r_q.ir);
        shifted = r_q.dr_sr >> 1;
        unique case (state_i)
            TLR:    r_d.ir    = INS_BYPASS;
            CAP_IR: r_d.ir_sr = IR_CAPTURE;
            SH_IR:  r_d.ir_sr = {tdi_i, r_q.ir_sr[IR_W-1:1]};
            UPD_IR: r_d.ir    = r_q.ir_sr;
            CAP_DR: begin
                case (r_q.ir)
                    INS_CTRL: r_d.dr_sr = SR_W'({r_q.ctl, r_q.req});
                    INS_EIR:  r_d.dr_sr = SR_W'(r_q.eir);
                    INS_STAT: r_d.dr_sr = SR_W'({emu_rdy_i, emu_ack_i});
                    INS_DATA: r_d.dr_sr = SR_W'(data_from_core_i);
                    INS_PC:   r_d.dr_sr = SR_W'(dbg_pc_i);
                    default:  r_d.dr_sr = '0;
                endcase
            end
            SH_DR: begin
                for (int i = 0; i < SR_W; i++) begin
                    if (i == len - 1)     r_d.dr_sr[i] = tdi_i;
                    else if (i < len - 1) r_d.dr_sr[i] = shifted[i];
                    else                  r_d.dr_sr[i] = 1'b0;
                end
            end
            UPD_DR: begin
                case (r_q.ir)
                    INS_CTRL: begin
                        r_d.req     = r_q.dr_sr[0];
                        r_d.ctl     = r_q.dr_sr[CTL_W:1];
                        r_d.upd_tog = ~r_q.upd_tog;
                    end
                    INS_EIR: begin
                        r_d.eir      = r_q.dr_sr[EIR_W-1:0];
                        r_d.upd_tog  = ~r_q.upd_tog;
                        r_d.exec_tog = ~r_q.exec_tog;
                    end
                    INS_DATA: begin
                        r_d.data    = r_q.dr_sr[DATA_W-1:0];
                        r_d.upd_tog = ~r_q.upd_tog;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ir: INS_BYPASS, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            tdo_q    <= (state_i == SH_IR) ? r_q.ir_sr[0] : r_q.dr_sr[0];
            tdo_en_q <= (state_i == SH_IR) || (state_i == SH_DR);
        end
    end

    assign tdo_o      = tdo_en_q ? tdo_q : 1'b0;
    assign tdo_en_o   = tdo_en_q;
    assign req_o      = r_q.req;
    assign ctl_o      = r_q.ctl;
    assign eir_o      = r_q.eir;
    assign data_o     = r_q.data;
    assign upd_tog_o  = r_q.upd_tog;
    assign exec_tog_o = r_q.exec_tog;

    // R1: Test-Logic-Reset forces the bypass instruction
    assert_tlr_bypass_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (state_i == TLR) |=> (r_q.ir == INS_BYPASS));

    // R5: output enable only while a shift state is active
    assert_oe_in_shift_R5: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en_q |-> ((state_i == SH_DR) || (state_i == SH_IR)));

    // R8: an update of the status register never signals the core side
    assert_stat_no_update_R8: assert property (@(posedge tck) disable iff (!rst_n)
        ((state_i == UPD_DR) && (r_q.ir == INS_STAT)) |=> $stable(r_q.upd_tog));

endmodule

// File: rtl/dbg_tap_sync.sv
module dbg_tap_sync #(
    parameter int CTL_W  = 4,
    parameter int EIR_W  = 8,
    parameter int DATA_W = 32,
    parameter int SYNC_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_tog_i,
    input  logic              exec_tog_i,
    input  logic              req_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [EIR_W-1:0]  eir_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              emu_req_o,
    output logic [CTL_W-1:0]  emu_ctl_o,
    output logic [EIR_W-1:0]  emu_ir_o,
    output logic              emu_exec_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int LAST = SYNC_N - 1;

    typedef struct packed {
        logic [SYNC_N-1:0] us;
        logic [SYNC_N-1:0] es;
        logic              req;
        logic [CTL_W-1:0]  ctl;
        logic [EIR_W-1:0]  eir;
        logic [DATA_W-1:0] data;
        logic              exec;
    } sync_t;

    sync_t s_d, s_q;
    logic  apply, fire;

    always_comb begin
        s_d    = s_q;
        s_d.us = {s_q.us[LAST-1:0], upd_tog_i};
        s_d.es = {s_q.es[LAST-1:0], exec_tog_i};
        apply  = s_q.us[LAST] ^ s_q.us[LAST-1];
        fire   = s_q.es[LAST] ^ s_q.es[LAST-1];
        s_d.exec = fire;
        if (apply) begin
            s_d.req  = req_i;
            s_d.ctl  = ctl_i;
            s_d.eir  = eir_i;
            s_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign emu_req_o  = s_q.req;
    assign emu_ctl_o  = s_q.ctl;
    assign emu_ir_o   = s_q.eir;
    assign emu_exec_o = s_q.exec;
    assign data_o     = s_q.data;

    // R7: the execute line is never high for two clk cycles in a row
    assert_exec_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        emu_exec_o |=> !emu_exec_o);

    // R6: the request level moves only on an announced update
    assert_req_on_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(emu_req_o) |-> $past(s_q.us[LAST] != s_q.us[LAST-1]));

    // R11: an execute pulse coincides with the registered bundle it belongs to
    assert_exec_with_bundle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        emu_exec_o |-> $past(s_q.us[LAST] != s_q.us[LAST-1]));

endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
    import dbg_tap_pkg::*;
#(
    parameter int CTL_W  = 4,
    parameter int EIR_W  = 8,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tck,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              emu_req,
    output logic [CTL_W-1:0]  emu_ctl,
    output logic [EIR_W-1:0]  emu_ir,
    output logic              emu_exec,
    input  logic              emu_ack,
    input  logic              emu_rdy,
    output logic [DATA_W-1:0] data_to_core,
    input  logic [DATA_W-1:0] data_from_core,
    input  logic [PC_W-1:0]   dbg_pc
);

    tap_state_e        state;
    logic              req_t, upd_tog, exec_tog;
    logic [CTL_W-1:0]  ctl_t;
    logic [EIR_W-1:0]  eir_t;
    logic [DATA_W-1:0] data_t;

    dbg_tap_fsm u_fsm (
        .tck     (tck),
        .rst_n   (rst_n),
        .tms_i   (tms),
        .state_o (state)
    );

    dbg_tap_regs #(
        .CTL_W (CTL_W), .EIR_W (EIR_W), .DATA_W (DATA_W), .PC_W (PC_W)
    ) u_regs (
        .tck              (tck),
        .rst_n            (rst_n),
        .tdi_i            (tdi),
        .state_i          (state),
        .emu_ack_i        (emu_ack),
        .emu_rdy_i        (emu_rdy),
        .data_from_core_i (data_from_core),
        .dbg_pc_i         (dbg_pc),
        .tdo_o            (tdo),
        .tdo_en_o         (tdo_oe),
        .req_o            (req_t),
        .ctl_o            (ctl_t),
        .eir_o            (eir_t),
        .data_o           (data_t),
        .upd_tog_o        (upd_tog),
        .exec_tog_o       (exec_tog)
    );

    dbg_tap_sync #(
        .CTL_W (CTL_W), .EIR_W (EIR_W), .DATA_W (DATA_W), .SYNC_N (3)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_tog_i  (upd_tog),
        .exec_tog_i (exec_tog),
        .req_i      (req_t),
        .ctl_i      (ctl_t),
        .eir_i      (eir_t),
        .data_i     (data_t),
        .emu_req_o  (emu_req),
        .emu_ctl_o  (emu_ctl),
        .emu_ir_o   (emu_ir),
        .emu_exec_o (emu_exec),
        .data_o     (data_to_core)
    );

endmodule

// File: tb/sim_dbg_tap.sv
`timescale 1ns/1ps
module sim_dbg_tap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        tdo, tdo_oe;
    logic        emu_req, emu_exec;
    logic [3:0]  emu_ctl;
    logic [7:0]  emu_ir;
    logic        emu_ack = 1'b0, emu_rdy = 1'b0;
    logic [31:0] data_to_core;
    logic [31:0] data_from_core = '0;
    logic [31:0] dbg_pc = '0;

    int n_chk = 0, n_fail = 0, n_exec = 0;
    bit done = 0;

    // expected core-side image and pending update
    logic        e_req = 0, p_req = 0;
    logic [3:0]  e_ctl = 0, p_ctl = 0;
    logic [7:0]  e_ir = 0, p_ir = 0;
    logic        e_exec = 0, p_exec = 0;
    logic [31:0] e_data = 0, p_data = 0;
    bit          arm = 0;

    always #2.5 clk = ~clk;

    dbg_tap u0 (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .emu_req(emu_req), .emu_ctl(emu_ctl),
        .emu_ir(emu_ir), .emu_exec(emu_exec), .emu_ack(emu_ack), .emu_rdy(emu_rdy),
        .data_to_core(data_to_core), .data_from_core(data_from_core), .dbg_pc(dbg_pc)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R11: outputs take the update on the third clk edge after the update edge
    always @(posedge tck) begin
        if (arm) begin
            fork
                begin
                    repeat (3) @(posedge clk);
                    #1;
                    e_req = p_req; e_ctl = p_ctl; e_ir = p_ir; e_data = p_data; e_exec = p_exec;
                    if (p_exec) begin
                        @(posedge clk);
                        #1;
                        e_exec = 1'b0;
                    end
                end
            join_none
        end
    end

    always @(posedge clk) if (rst_n && emu_exec) n_exec++;

    // per-cycle comparison against the expected image (R1, R6, R7, R9, R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(emu_req == e_req && emu_ctl == e_ctl, "R6/R11 ctrl", {emu_ctl, emu_req}, {e_ctl, e_req});
            chk(emu_ir == e_ir && emu_exec == e_exec, "R7/R11 exec", {emu_ir, emu_exec}, {e_ir, e_exec});
            chk(data_to_core == e_data, "R9/R11 data", data_to_core, e_data);
        end
    end

    task automatic tclk(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        #10;
        o = tdo;
        tck = 1'b1;
        #20;
        tck = 1'b0;
        #10;
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        tclk(1, 0, o); tclk(1, 0, o); tclk(0, 0, o); tclk(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tclk(i == 3, code[i], o);
            cap[i] = o;
        end
        tclk(1, 0, o); tclk(0, 0, o);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, input bit upd,
                           output logic [63:0] dout);
        logic o;
        bit   oe_ok = 1;
        dout = '0;
        tclk(1, 0, o); tclk(0, 0, o); tclk(0, 0, o);
        for (int i = 0; i < len; i++) begin
            if (tdo_oe !== 1'b1) oe_ok = 0;
            tclk(i == len - 1, din[i], o);
            dout[i] = o;
        end
        tclk(1, 0, o);
        arm = upd;
        tclk(0, 0, o);
        arm = 0;
        chk(oe_ok, "R5 oe high in shift", 0, 1);
        chk(tdo_oe == 1'b0, "R5 oe low in idle", tdo_oe, 0);
    endtask

    logic [3:0]  cap;
    logic [63:0] dout;
    logic        ob;

    initial begin
        #20 rst_n = 1'b1;
        @(posedge clk); #1.25;
        chk({emu_req, emu_ctl, emu_ir, emu_exec, data_to_core} == '0, "R1 reset outputs",
            {emu_req, emu_ctl, emu_ir, emu_exec}, 0);
        chk(tdo_oe == 1'b0, "R5 oe after reset", tdo_oe, 0);
        tclk(0, 0, ob);

        // R1/R4: reset selects bypass, one-cycle delay
        scan_dr(9, 64'h0B5, 0, dout);
        chk(dout[8:0] == {8'hB5, 1'b0}, "R1/R4 bypass after reset", dout[8:0], {8'hB5, 1'b0});

        // R2/R3/R8: status capture, update has no effect
        emu_ack = 1; emu_rdy = 0;
        scan_ir(4'h3, cap);
        chk(cap == 4'b0001, "R2 IR capture", cap, 4'b0001);
        scan_dr(2, 64'h3, 0, dout);
        chk(dout[1:0] == 2'b01, "R8 status ack", dout[1:0], 2'b01);
        emu_rdy = 1;
        scan_dr(2, 64'h0, 0, dout);
        chk(dout[1:0] == 2'b11, "R8 status ack+rdy", dout[1:0], 2'b11);

        // R6: control write then read back
        scan_ir(4'h1, cap);
        chk(cap == 4'b0001, "R2 IR capture again", cap, 4'b0001);
        p_req = 1; p_ctl = 4'hA; p_ir = e_ir; p_data = e_data; p_exec = 0;
        scan_dr(5, 64'h15, 1, dout);
        chk(dout[4:0] == 5'h00, "R6 control initial", dout[4:0], 0);
        scan_dr(5, 64'h15, 1, dout);
        chk(dout[4:0] == 5'h15, "R6 control read back", dout[4:0], 5'h15);
        chk(emu_req == 1'b1, "R6 request level held", emu_req, 1);

        // R7: two instruction updates, two pulses
        scan_ir(4'h2, cap);
        p_ir = 8'h3C; p_exec = 1;
        scan_dr(8, 64'h3C, 1, dout);
        p_ir = 8'hC3;
        scan_dr(8, 64'hC3, 1, dout);
        chk(dout[7:0] == 8'h3C, "R7 instruction read back", dout[7:0], 8'h3C);
        repeat (6) @(posedge clk);
        #1.25;
        chk(n_exec == 2, "R7 one pulse per update", n_exec, 2);
        p_exec = 0;

        // R9: data exchange both ways
        scan_ir(4'h4, cap);
        data_from_core = 32'hDEADBEEF;
        p_data = 32'h12345678;
        scan_dr(32, 64'h12345678, 1, dout);
        chk(dout[31:0] == 32'hDEADBEEF, "R9 data capture", dout[31:0], 32'hDEADBEEF);

        // R4: longer chain passes input straight through after 32 cycles
        data_from_core = 32'h0F0F_1234;
        p_data = 32'hAB_5566_77;
        scan_dr(40, 64'hAB_5566_7799, 1, dout);
        chk(dout[31:0] == 32'h0F0F_1234, "R4 chain capture part", dout[31:0], 32'h0F0F_1234);
        chk(dout[39:32] == 8'h99, "R4 chain pass-through", dout[39:32], 8'h99);

        // R10: live program counter, request untouched
        scan_ir(4'h5, cap);
        dbg_pc = 32'h0000_1F40;
        scan_dr(32, 64'h0, 1, dout);
        chk(dout[31:0] == 32'h0000_1F40, "R10 pc capture", dout[31:0], 32'h1F40);
        chk(emu_req == 1'b1, "R10 request kept", emu_req, 1);

        // R3: unknown code selects bypass
        scan_ir(4'h9, cap);
        scan_dr(9, 64'h1C3, 0, dout);
        chk(dout[8:0] == {8'hC3, 1'b0}, "R3 unknown is bypass", dout[8:0], {8'hC3, 1'b0});

        // R1: five mode-high edges restore bypass, outputs untouched
        scan_ir(4'h4, cap);
        for (int i = 0; i < 5; i++) tclk(1, 0, ob);
        tclk(0, 0, ob);
        scan_dr(9, 64'h0A5, 0, dout);
        chk(dout[8:0] == {8'hA5, 1'b0}, "R1 soft reset bypass", dout[8:0], {8'hA5, 1'b0});
        chk(data_to_core == 32'hAB_5566_77, "R1 soft reset keeps data", data_to_core, 32'hAB556677);

        // R6: drop the request
        scan_ir(4'h1, cap);
        p_req = 0; p_ctl = 4'h0;
        scan_dr(5, 64'h0, 1, dout);
        repeat (6) @(posedge clk);
        #1.25;
        chk(emu_req == 1'b0, "R6 request released", emu_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule